// File: doc/BRIEF.md
# Four-Lane Conditioner Configuration Target

This block is the two-wire serial configuration target of a four-lane signal-conditioning device. It owns eleven byte registers. They hold the per-lane settings the analog lanes consume: lane enables, equalizer boost, output swing, de-emphasis, receiver-detect power-down, receiver reset, activity-detector disable and activity threshold. A read-only byte reports lane activity. The target answers one 7-bit address. Two fixed ones, two fixed zeros and three strap pins form that address.

Every transfer starts at register index 0, and the index advances by one after each byte. There is no offset pointer. In a write, the byte that follows the address is taken as an offset and thrown away. The settings registers are loaded from strap pins just after reset. A pin-mode input chooses what feeds the lane outputs for enable, boost, swing and de-emphasis: with pin-mode high the strap pins drive all four lanes alike, and with pin-mode low the registers drive each lane. Both bus lines pass through a two-flop synchronizer and a glitch filter before START and STOP are detected. The target never stretches the clock.

Top module: `retimer_cfg_target`

## Requirements
- R1: The target acknowledges only the address {1,1,addr_strap[2],0,0,addr_strap[1],addr_strap[0]} (MSB first), with the eighth bit 1 for read and 0 for write. Any other address gets no ACK, and SDA is left released.
- R2: In a write, every byte is acknowledged. The first byte after the address is discarded. The following bytes land in register indices 0, 1, 2 and onward in turn.
- R3: A read returns register indices 0, 1, 2 and onward in turn, one byte per master ACK, MSB first. The target releases SDA once the master answers a byte with NACK.
- R4: Index 0 reads {lane_active[3:0], 4'b0000}. Indices 1, 7 and 11 to 15 read 0. Writes to indices 0, 1, 7 and 11 to 15 are acknowledged and change no state.
- R5: In the first clock after reset is released, the registers load their startup values:
  - index 2 = {4{pen_strap}, 0000}
  - indices 3 and 4 = {boost_strap, boost_strap}
  - index 5 = {4{swing_strap, 1}}
  - index 6 = {4{deemph_strap}}
  - index 8 = 8'hF0
  - indices 9 and 10 = 0
- R6: The register fields map to the lane outputs as follows:
  - Enables: lane_en[3:0] = index 2 bits 7..4.
  - Boost: lane_boost = {idx4, idx3}, with lane n in bits 4n+3..4n.
  - Swing: lane_swing = idx5, with lane n in bits 2n+1..2n.
  - De-emphasis: lane_deemph = idx6, laid out the same way as swing.
  - Index 8: lane_det_pd = bits 7..4 and lane_rx_rst = bits 3..0.
  - Activity disables: lane_act_dis = index 9 bits 7..4.
  - Thresholds: lane_thresh = idx10, two bits per lane, laid out the same way as swing.
- R7: With pin_mode high, the straps drive all lanes alike:
  - lane_en = {4{pen_strap}}
  - lane_boost = {4{boost_strap}}
  - lane_swing = {4{swing_strap, 1}}
  - lane_deemph = {4{deemph_strap}}

  This follows the straps live. Power-down, receiver reset, activity disable and threshold always come from the registers. The register contents stay readable in both modes.
- R8: Bits 3..0 of indices 2 and 9 are not stored and read 0.
- R9: A repeated START resets the index to 0 and begins a new transfer. A STOP returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | 3 | Address strap pins, high to low |
| pen_strap | input | 1 | Power-enable strap |
| boost_strap | input | 4 | Equalizer boost strap |
| swing_strap | input | 1 | Swing strap |
| deemph_strap | input | 2 | De-emphasis strap |
| pin_mode | input | 1 | 1 means straps drive the lanes |
| lane_active | input | 4 | Activity flags of lanes 3..0 |
| lane_en | output | 4 | Lane enables |
| lane_boost | output | 16 | Boost codes, 4 bits per lane |
| lane_swing | output | 8 | Swing codes, 2 bits per lane |
| lane_deemph | output | 8 | De-emphasis codes, 2 bits per lane |
| lane_det_pd | output | 4 | Receiver-detect power-down |
| lane_rx_rst | output | 4 | Receiver reset |
| lane_act_dis | output | 4 | Activity-detector disable |
| lane_thresh | output | 8 | Activity threshold codes, 2 bits per lane |

## Verification
Each bus-line edge reaches the protocol engine two synchronizer cycles plus the filter length after it occurs on the pad, about six clocks in all. The target therefore drives an ACK or data bit about six clocks after the SCL fall that precedes it. The bench drives each bus phase for ten clocks and samples SDA in the middle of the SCL-high phase, well after that delay. A register write lands on the internal SCL fall that ends its ACK-preceding bit, so lane outputs are checked only after the STOP. Strap-driven outputs in pin mode are combinational and are checked one clock after the strap changes. The startup values are checked a few clocks after reset release.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int NLANE = 4;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_MAX = 4'hF;

  typedef enum logic [2:0] {
    E_IDLE, E_ADDR, E_ADDR_ACK, E_WR, E_WR_ACK, E_RD, E_RD_ACK
  } eng_state_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic s1_q, s2_q, clean_q, clean_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    clean_d = clean_q;
    cnt_d   = '0;
    if (s2_q != clean_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) clean_d = s2_q;
      else cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      clean_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      s1_q    <= raw;
      s2_q    <= s1_q;
      clean_q <= clean_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/i2c_engine.sv
module i2c_engine
  import rcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic [6:0]       my_addr,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             stop_det,
  output logic             sda_oe
);
  eng_state_t st_q, st_d;
  logic [3:0] bitc_q, bitc_d;
  logic [7:0] sh_q, sh_d, tx_q, tx_d;
  logic [IDX_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic dummy_q, dummy_d;
  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_det;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign ptr_inc   = (ptr_q == IDX_MAX) ? ptr_q : ptr_q + 1'b1;

  assign wr_en   = (st_q == E_WR) && scl_fall && (bitc_q == 4'd8) && !dummy_q;
  assign wr_data = sh_q;
  assign idx     = ptr_q;
  assign sda_oe  = (st_q == E_ADDR_ACK) || (st_q == E_WR_ACK) ||
                   ((st_q == E_RD) && !tx_q[7]);

  always_comb begin
    st_d    = st_q;
    bitc_d  = bitc_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    dummy_d = dummy_q;
    if (start_det) begin
      st_d    = E_ADDR;
      bitc_d  = '0;
      ptr_d   = '0;
      dummy_d = 1'b1;
    end else if (stop_det) begin
      st_d = E_IDLE;
    end else begin
      unique case (st_q)
        E_ADDR, E_WR: begin
          if (scl_rise) begin
            sh_d   = {sh_q[6:0], sda_f};
            bitc_d = bitc_q + 1'b1;
          end else if (scl_fall && bitc_q == 4'd8) begin
            if (st_q == E_WR) begin
              st_d = E_WR_ACK;
              if (dummy_q) dummy_d = 1'b0;
              else ptr_d = ptr_inc;
            end else if (sh_q[7:1] == my_addr) begin
              st_d = E_ADDR_ACK;
            end else begin
              st_d = E_IDLE;
            end
          end
        end
        E_ADDR_ACK: if (scl_fall) begin
          bitc_d = '0;
          if (sh_q[0]) begin
            st_d = E_RD;
            tx_d = rd_data;
          end else begin
            st_d = E_WR;
          end
        end
        E_WR_ACK: if (scl_fall) begin
          st_d   = E_WR;
          bitc_d = '0;
        end
        E_RD: begin
          if (scl_rise) bitc_d = bitc_q + 1'b1;
          else if (scl_fall) begin
            if (bitc_q == 4'd8) st_d = E_RD_ACK;
            else tx_d = {tx_q[6:0], 1'b0};
          end
        end
        E_RD_ACK: begin
          if (scl_rise) begin
            if (sda_f) st_d = E_IDLE;
            else ptr_d = ptr_inc;
          end else if (scl_fall) begin
            st_d   = E_RD;
            bitc_d = '0;
            tx_d   = rd_data;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      bitc_q  <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      ptr_q   <= '0;
      dummy_q <= 1'b1;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      bitc_q  <= bitc_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      dummy_q <= dummy_d;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import rcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             pen_strap,
  input  logic [3:0]       boost_strap,
  input  logic             swing_strap,
  input  logic [1:0]       deemph_strap,
  input  logic             pin_mode,
  input  logic [NLANE-1:0] lane_active,
  output logic [NLANE-1:0] lane_en,
  output logic [4*NLANE-1:0] lane_boost,
  output logic [2*NLANE-1:0] lane_swing,
  output logic [2*NLANE-1:0] lane_deemph,
  output logic [NLANE-1:0] lane_det_pd,
  output logic [NLANE-1:0] lane_rx_rst,
  output logic [NLANE-1:0] lane_act_dis,
  output logic [2*NLANE-1:0] lane_thresh
);
  logic [NLANE-1:0]   en_q, en_d, pd_q, pd_d, rr_q, rr_d, ad_q, ad_d;
  logic [4*NLANE-1:0] bst_q, bst_d;
  logic [2*NLANE-1:0] sw_q, sw_d, de_q, de_d, th_q, th_d;
  logic boot_q;
  logic [2*NLANE-1:0] sw_pins;

  assign sw_pins = {NLANE{swing_strap, 1'b1}};

  always_comb begin
    en_d = en_q; bst_d = bst_q; sw_d = sw_q; de_d = de_q;
    pd_d = pd_q; rr_d = rr_q; ad_d = ad_q; th_d = th_q;
    if (!boot_q) begin
      en_d  = {NLANE{pen_strap}};
      bst_d = {NLANE{boost_strap}};
      sw_d  = sw_pins;
      de_d  = {NLANE{deemph_strap}};
    end else if (wr_en) begin
      unique case (idx)
        4'h2: en_d = wr_data[7:4];
        4'h3: bst_d[7:0] = wr_data;
        4'h4: bst_d[15:8] = wr_data;
        4'h5: sw_d = wr_data;
        4'h6: de_d = wr_data;
        4'h8: begin pd_d = wr_data[7:4]; rr_d = wr_data[3:0]; end
        4'h9: ad_d = wr_data[7:4];
        4'hA: th_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b0;
      en_q <= '0; bst_q <= '0; sw_q <= '0; de_q <= '0;
      pd_q <= '1; rr_q <= '0; ad_q <= '0; th_q <= '0;
    end else begin
      boot_q <= 1'b1;
      en_q <= en_d; bst_q <= bst_d; sw_q <= sw_d; de_q <= de_d;
      pd_q <= pd_d; rr_q <= rr_d; ad_q <= ad_d; th_q <= th_d;
    end
  end

  always_comb begin
    unique case (idx)
      4'h0: rd_data = {lane_active, 4'b0000};
      4'h2: rd_data = {en_q, 4'b0000};
      4'h3: rd_data = bst_q[7:0];
      4'h4: rd_data = bst_q[15:8];
      4'h5: rd_data = sw_q;
      4'h6: rd_data = de_q;
      4'h8: rd_data = {pd_q, rr_q};
      4'h9: rd_data = {ad_q, 4'b0000};
      4'hA: rd_data = th_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign lane_en      = pin_mode ? {NLANE{pen_strap}} : en_q;
  assign lane_boost   = pin_mode ? {NLANE{boost_strap}} : bst_q;
  assign lane_swing   = pin_mode ? sw_pins : sw_q;
  assign lane_deemph  = pin_mode ? {NLANE{deemph_strap}} : de_q;
  assign lane_det_pd  = pd_q;
  assign lane_rx_rst  = rr_q;
  assign lane_act_dis = ad_q;
  assign lane_thresh  = th_q;
endmodule

// File: rtl/retimer_cfg_target.sv
module retimer_cfg_target #(
  parameter int FILT_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_strap,
  input  logic        pen_strap,
  input  logic [3:0]  boost_strap,
  input  logic        swing_strap,
  input  logic [1:0]  deemph_strap,
  input  logic        pin_mode,
  input  logic [3:0]  lane_active,
  output logic [3:0]  lane_en,
  output logic [15:0] lane_boost,
  output logic [7:0]  lane_swing,
  output logic [7:0]  lane_deemph,
  output logic [3:0]  lane_det_pd,
  output logic [3:0]  lane_rx_rst,
  output logic [3:0]  lane_act_dis,
  output logic [7:0]  lane_thresh
);
  import rcfg_pkg::*;

  logic [1:0] raw_lines, clean_lines;
  logic [IDX_W-1:0] idx;
  logic [7:0] rd_data, wr_data;
  logic wr_en, stop_det;
  logic [6:0] my_addr;

  assign raw_lines = {scl_i, sda_i};
  assign my_addr   = {2'b11, addr_strap[2], 2'b00, addr_strap[1:0]};

  for (genvar g = 0; g < 2; g++) begin : g_line
    line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .clean(clean_lines[g])
    );
  end

  i2c_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(clean_lines[1]), .sda_f(clean_lines[0]),
    .my_addr(my_addr), .rd_data(rd_data), .idx(idx), .wr_en(wr_en),
    .wr_data(wr_data), .stop_det(stop_det), .sda_oe(sda_oe)
  );

  cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wr_data(wr_data),
    .rd_data(rd_data), .pen_strap(pen_strap), .boost_strap(boost_strap),
    .swing_strap(swing_strap), .deemph_strap(deemph_strap),
    .pin_mode(pin_mode), .lane_active(lane_active), .lane_en(lane_en),
    .lane_boost(lane_boost), .lane_swing(lane_swing),
    .lane_deemph(lane_deemph), .lane_det_pd(lane_det_pd),
    .lane_rx_rst(lane_rx_rst), .lane_act_dis(lane_act_dis),
    .lane_thresh(lane_thresh)
  );
endmodule

// File: rtl/retimer_cfg_target_chk.sv
module retimer_cfg_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pin_mode,
  input logic [3:0]  boost_strap,
  input logic [15:0] lane_boost,
  input logic        sda_oe,
  input logic        stop_det,
  input logic        wr_en,
  input logic [3:0]  idx,
  input logic [3:0]  lane_rx_rst,
  input logic [7:0]  lane_thresh
);
  p_pin_boost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode |-> lane_boost == {4{boost_strap}});

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_wr_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sda_oe);

  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lane_rx_rst) && $stable(lane_thresh));

  p_reserved_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == 4'h7 || idx > 4'hA)) |=>
      $stable(lane_rx_rst) && $stable(lane_thresh));
endmodule

bind retimer_cfg_target retimer_cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .boost_strap(boost_strap),
  .lane_boost(lane_boost), .sda_oe(sda_oe), .stop_det(stop_det),
  .wr_en(wr_en), .idx(idx), .lane_rx_rst(lane_rx_rst),
  .lane_thresh(lane_thresh)
);

// File: tb/tb_retimer_cfg_target.sv
module tb_retimer_cfg_target;
  localparam int QC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [2:0] addr_strap = 3'b101;
  logic pen_strap = 1'b1;
  logic [3:0] boost_strap = 4'hA;
  logic swing_strap = 1'b0;
  logic [1:0] deemph_strap = 2'b10;
  logic pin_mode = 1'b0;
  logic [3:0] lane_active = 4'b0101;
  logic [3:0] lane_en, lane_det_pd, lane_rx_rst, lane_act_dis;
  logic [15:0] lane_boost;
  logic [7:0] lane_swing, lane_deemph, lane_thresh;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mon_val;
  event byte_ev;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  retimer_cfg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_strap(addr_strap), .pen_strap(pen_strap),
    .boost_strap(boost_strap), .swing_strap(swing_strap),
    .deemph_strap(deemph_strap), .pin_mode(pin_mode),
    .lane_active(lane_active), .lane_en(lane_en), .lane_boost(lane_boost),
    .lane_swing(lane_swing), .lane_deemph(lane_deemph),
    .lane_det_pd(lane_det_pd), .lane_rx_rst(lane_rx_rst),
    .lane_act_dis(lane_act_dis), .lane_thresh(lane_thresh)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(QC); scl_m = 1'b1; wq(QC);
    sda_m = 1'b0; wq(QC); scl_m = 1'b0; wq(QC);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(QC); scl_m = 1'b1; wq(QC); sda_m = 1'b1; wq(2*QC);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(QC); scl_m = 1'b1; wq(2*QC); scl_m = 1'b0; wq(QC);
    end
    sda_m = 1'b1; wq(QC); scl_m = 1'b1; wq(QC);
    ack = ~sda_line;
    wq(QC); scl_m = 1'b0; wq(QC);
  endtask

  task automatic recv_byte(input logic nack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(QC); scl_m = 1'b1; wq(QC); b[i] = sda_line; wq(QC); scl_m = 1'b0; wq(QC);
    end
    sda_m = nack; wq(QC); scl_m = 1'b1; wq(2*QC); scl_m = 1'b0; wq(QC);
    sda_m = 1'b1;
    mon_val = b;
    -> byte_ev;
    wq(1);
  endtask

  // driver: pushes expected bytes, then clocks them out of the target
  task automatic read_block(input string tag, input logic [7:0] exp_bytes[], input bit restart);
    logic ack;
    if (restart) bus_start();
    else bus_start();
    send_byte({2'b11, addr_strap[2], 2'b00, addr_strap[1:0], 1'b1}, ack);
    check({tag, " read address ACK (R1)"}, ack, 1);
    foreach (exp_bytes[i]) begin
      exp_q.push_back(exp_bytes[i]);
      tag_q.push_back($sformatf("%s byte %0d", tag, i));
      recv_byte(i == exp_bytes.size() - 1);
    end
    bus_stop();
    check({tag, " SDA released after NACK and STOP (R3)"}, sda_oe, 0);
  endtask

  // monitor: compares each byte the target returns against the queue
  initial begin
    forever begin
      @(byte_ev);
      if (exp_q.size() == 0) check("R3 unexpected byte", mon_val, 8'hxx);
      else check(tag_q.pop_front(), mon_val, exp_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] wr_bytes[12];
    wq(5); rst_n = 1'b1; wq(5);

    // R5/R6 startup values seen at lane outputs
    check("R5 lane_en boot", lane_en, 4'hF);
    check("R5 lane_boost boot", lane_boost, 16'hAAAA);
    check("R5 lane_swing boot", lane_swing, 8'h55);
    check("R5 lane_deemph boot", lane_deemph, 8'hAA);
    check("R5 lane_det_pd boot", lane_det_pd, 4'hF);
    check("R5 lane_rx_rst boot", {lane_rx_rst, lane_act_dis, lane_thresh}, 16'h0);
    check("R1 idle SDA released", sda_oe, 0);

    // R3/R4/R5 full read from index 0
    read_block("R3 R4 R5 boot read",
      '{8'h50, 8'h00, 8'hF0, 8'hAA, 8'hAA, 8'h55, 8'hAA, 8'h00, 8'hF0, 8'h00, 8'h00, 8'h00}, 0);

    // R1 wrong address: no ACK
    bus_start();
    send_byte({7'b1110011, 1'b0}, ack);
    check("R1 foreign address not acknowledged", ack, 0);
    bus_stop();

    // R2 write with dummy offset, then registers 0..11
    wr_bytes = '{8'h3C, 8'hFF, 8'hFF, 8'h5F, 8'h21, 8'h43, 8'hE4, 8'h1B, 8'hFF,
                 8'hA5, 8'h9F, 8'hC6};
    bus_start();
    send_byte({7'b1110001, 1'b0}, ack);
    check("R1 write address ACK", ack, 1);
    foreach (wr_bytes[i]) begin
      send_byte(wr_bytes[i], ack);
      check($sformatf("R2 write byte %0d ACK", i), ack, 1);
    end
    send_byte(8'h77, ack);
    check("R4 write to index 11 ACK", ack, 1);
    bus_stop();

    // R6 mapping after writes
    check("R6 lane_en", lane_en, 4'h5);
    check("R6 lane_boost", lane_boost, 16'h4321);
    check("R6 lane_swing", lane_swing, 8'hE4);
    check("R6 lane_deemph", lane_deemph, 8'h1B);
    check("R6 lane_det_pd", lane_det_pd, 4'hA);
    check("R6 lane_rx_rst", lane_rx_rst, 4'h5);
    check("R6 lane_act_dis", lane_act_dis, 4'h9);
    check("R6 lane_thresh", lane_thresh, 8'hC6);

    // R9 repeated start: write address + dummy, then restart as read
    bus_start();
    send_byte({7'b1110001, 1'b0}, ack);
    send_byte(8'h07, ack);
    check("R9 dummy before restart ACK", ack, 1);
    sda_m = 1'b1; wq(QC);
    read_block("R9 R8 R4 readback after restart",
      '{8'h50, 8'h00, 8'h50, 8'h21, 8'h43, 8'hE4, 8'h1B, 8'h00, 8'hA5, 8'h90, 8'hC6, 8'h00}, 1);

    // R7 pin mode
    pin_mode = 1'b1; wq(2);
    check("R7 pin lane_en", lane_en, 4'hF);
    check("R7 pin lane_boost", lane_boost, 16'hAAAA);
    check("R7 pin lane_swing", lane_swing, 8'h55);
    check("R7 pin lane_deemph", lane_deemph, 8'hAA);
    check("R7 registers still drive det_pd/thresh", {lane_det_pd, lane_thresh}, 12'hAC6);
    boost_strap = 4'h3; swing_strap = 1'b1; wq(2);
    check("R7 live strap boost", lane_boost, 16'h3333);
    check("R7 live strap swing", lane_swing, 8'hFF);
    lane_active = 4'b1010;
    read_block("R7 R4 registers readable in pin mode",
      '{8'hA0, 8'h00, 8'h50, 8'h21}, 0);
    pin_mode = 1'b0; wq(2);
    check("R7 back to register boost", lane_boost, 16'h4321);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule